// File: doc/BRIEF.md
# Configurable General-Purpose Pin Controller

This block owns a single general-purpose I/O pin. One 8-bit configuration word sets everything about the pin. It chooses whether the pin drives or listens, and whether the observed and driven levels are inverted. It also chooses whether an output drives both levels or only pulls low, whether the pin may raise an interrupt, and which function owns the pin. The owner is either plain software-controlled GPIO or one of three alternate functions. Each alternate function decides the pad direction itself. Any alternate input that is not selected presents a constant inactive high level to its consumer.

The configuration word can only be changed while the chip-level configuration-mode enable is high. The pad input passes through a synchronizer. After synchronization it is presented as a GPIO data bit with the polarity setting applied, and it is also routed to whichever alternate input is selected. The interrupt request is the enabled, polarity-corrected pad level. Open-drain behaviour is built by gating the output enable, so the pad is never actively driven high in that mode.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset the configuration word is 0x00 (input, non-inverting, GPIO function, interrupt off, push-pull). `cfg_rdata` returns the word while `cfg_mode` is 1 and reads 0x00 while `cfg_mode` is 0.
- R2: A write (`cfg_wr` = 1) changes the word on the next clock edge only when `cfg_mode` is 1; otherwise it has no effect. Bits 2 and 6 are reserved and always read 0.
- R3: With function code 00 (bits [4:3]), bit 0 = 0 makes the pin an input (`pad_oe` = 0, `pad_out` = 0). Bit 0 = 1 drives `gpio_wdata` XOR bit 1 onto the pad.
- R4: Bit 7 = 1 selects open-drain: a driven 0 gives `pad_oe` = 1 with `pad_out` = 0, and a driven 1 gives `pad_oe` = 0. The pad is never driven high in this mode.
- R5: `gpio_rdata` equals `pad_in` XOR bit 1, delayed by two clock edges of synchronization.
- R6: Function code 01 is an alternate output. The pad carries `alt_drv[0]` whatever bit 0 and bit 1 hold, and bit 7 still selects open-drain or push-pull.
- R7: Function codes 10 and 11 are alternate inputs whose pads are never driven, whatever bit 0 holds. Code 10 presents the synchronized pad level XOR bit 1 on `alt_rcv[1]`. Code 11 presents the synchronized pad level on `alt_rcv[2]` and ignores bit 1.
- R8: Every `alt_rcv` bit whose function is not selected reads 1, and `alt_rcv[0]` (an output slot) always reads 1.
- R9: `irq` is 1 exactly when bit 5 is 1 and the polarity-corrected synchronized pad level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Chip-level configuration-mode enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Level to drive onto the pad |
| pad_oe | output | 1 | Pad output enable |
| gpio_wdata | input | 1 | GPIO data bit to drive |
| gpio_rdata | output | 1 | GPIO data bit read from the pad |
| alt_drv | input | 3 | Alternate output signals, one per function slot |
| alt_rcv | output | 3 | Alternate input signals, one per function slot |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The word never moves outside configuration mode, and the reserved bits stay zero. Read data is blanked outside configuration mode. An open-drain pad is never driven high, and a GPIO input never drives the pad. Unselected alternate inputs sit high in GPIO mode, and the interrupt never fires while it is disabled. The bench scenarios show the rest. These are the value mapping through each function code, the polarity exception for code 10 against code 11, the fact that the direction bit is overridden in alternate modes, and the two-edge input latency.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int CFG_W = 8;
    localparam int N_ALT = 3;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_ALT1 = 2'b01,
        FN_ALT2 = 2'b10,
        FN_ALT3 = 2'b11
    } pin_fn_e;

    // Bit layout: [7] open-drain, [6] reserved, [5] irq enable,
    // [4:3] function, [2] reserved, [1] invert, [0] drive (output)
    typedef struct packed {
        logic    open_drain;
        logic    rsv6;
        logic    irq_en;
        pin_fn_e fn;
        logic    rsv2;
        logic    invert;
        logic    dir_out;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '0;

endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output pin_cfg_t         cfg_q,
    output logic [CFG_W-1:0] cfg_rdata
);

    pin_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_mode && cfg_wr) begin
            cfg_d      = pin_cfg_t'(cfg_wdata);
            cfg_d.rsv6 = 1'b0;
            cfg_d.rsv2 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_rdata = cfg_mode ? CFG_W'(cfg_q) : '0;

endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path
    import gpio_pin_pkg::*;
#(
    parameter int               SYNC_STAGES  = 2,
    parameter logic [N_ALT-1:0] ALT_OUT_MASK = 3'b001,
    parameter int               POL_ALT_SLOT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_in,
    input  pin_cfg_t         cfg,
    output logic             gpio_rdata,
    output logic [N_ALT-1:0] alt_rcv,
    output logic             irq
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
    } in_state_t;

    in_state_t st_d, st_q;
    logic      raw_lvl;
    logic      pol_lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pad_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_lvl    = st_q.sync[SYNC_STAGES-1];
    assign pol_lvl    = raw_lvl ^ cfg.invert;
    assign gpio_rdata = pol_lvl;
    assign irq        = cfg.irq_en & pol_lvl;

    for (genvar k = 0; k < N_ALT; k++) begin : g_alt_in
        logic sel;
        assign sel = (cfg.fn == pin_fn_e'(k + 1));
        if (ALT_OUT_MASK[k]) begin : g_out_slot
            assign alt_rcv[k] = 1'b1;
        end else if (k == POL_ALT_SLOT) begin : g_pol_slot
            assign alt_rcv[k] = sel ? pol_lvl : 1'b1;
        end else begin : g_raw_slot
            assign alt_rcv[k] = sel ? raw_lvl : 1'b1;
        end
    end

endmodule

// File: rtl/gpio_out_path.sv
module gpio_out_path
    import gpio_pin_pkg::*;
#(
    parameter logic [N_ALT-1:0] ALT_OUT_MASK = 3'b001
) (
    input  pin_cfg_t         cfg,
    input  logic             gpio_wdata,
    input  logic [N_ALT-1:0] alt_drv,
    output logic             pad_out,
    output logic             pad_oe
);

    logic drive_en;
    logic drive_val;

    always_comb begin
        drive_en  = 1'b0;
        drive_val = 1'b0;
        if (cfg.fn == FN_GPIO) begin
            drive_en  = cfg.dir_out;
            drive_val = gpio_wdata ^ cfg.invert;
        end else begin
            for (int k = 0; k < N_ALT; k++) begin
                if (cfg.fn == pin_fn_e'(k + 1)) begin
                    drive_en  = ALT_OUT_MASK[k];
                    drive_val = alt_drv[k];
                end
            end
        end
    end

    always_comb begin
        pad_oe  = 1'b0;
        pad_out = 1'b0;
        if (drive_en) begin
            if (cfg.open_drain) begin
                pad_oe  = ~drive_val;
                pad_out = 1'b0;
            end else begin
                pad_oe  = 1'b1;
                pad_out = drive_val;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int               SYNC_STAGES  = 2,
    parameter logic [N_ALT-1:0] ALT_OUT_MASK = 3'b001,
    parameter int               POL_ALT_SLOT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    input  logic             gpio_wdata,
    output logic             gpio_rdata,
    input  logic [N_ALT-1:0] alt_drv,
    output logic [N_ALT-1:0] alt_rcv,
    output logic             irq
);

    pin_cfg_t cfg_word;

    gpio_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_word),
        .cfg_rdata (cfg_rdata)
    );

    gpio_in_path #(
        .SYNC_STAGES  (SYNC_STAGES),
        .ALT_OUT_MASK (ALT_OUT_MASK),
        .POL_ALT_SLOT (POL_ALT_SLOT)
    ) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_in     (pad_in),
        .cfg        (cfg_word),
        .gpio_rdata (gpio_rdata),
        .alt_rcv    (alt_rcv),
        .irq        (irq)
    );

    gpio_out_path #(
        .ALT_OUT_MASK (ALT_OUT_MASK)
    ) u_out (
        .cfg        (cfg_word),
        .gpio_wdata (gpio_wdata),
        .alt_drv    (alt_drv),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk
    import gpio_pin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_mode,
    input pin_cfg_t         cfg_word,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             pad_out,
    input logic             pad_oe,
    input logic [N_ALT-1:0] alt_rcv,
    input logic             irq
);

    p_rdata_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> (cfg_rdata == '0));

    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(cfg_word));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word.rsv2 == 1'b0) && (cfg_word.rsv6 == 1'b0));

    p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word.fn == FN_GPIO && !cfg_word.dir_out) |-> !pad_oe);

    p_od_low_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word.open_drain && pad_oe) |-> !pad_out);

    p_alt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word.fn == FN_GPIO) |-> (alt_rcv == '1));

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_word.irq_en);

endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_word  (cfg_word),
    .cfg_rdata (cfg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .alt_rcv   (alt_rcv),
    .irq       (irq)
);

// File: tb/test_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       pad_in = 1'b0;
    logic       pad_out;
    logic       pad_oe;
    logic       gpio_wdata = 1'b0;
    logic       gpio_rdata;
    logic [2:0] alt_drv = '0;
    logic [2:0] alt_rcv;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_pin_ctrl i_gpio_pin_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .gpio_wdata (gpio_wdata),
        .gpio_rdata (gpio_rdata),
        .alt_drv    (alt_drv),
        .alt_rcv    (alt_rcv),
        .irq        (irq)
    );

    typedef struct packed {
        logic [7:0] cfg;
        logic       wd;
        logic [2:0] ad;
        logic       pin;
        logic       oe;
        logic       out;
        logic       rd;
        logic [2:0] ar;
        logic       irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0}, // R3 input
        '{8'h02, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 1'b0}, // R5 invert
        '{8'h20, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1}, // R9 irq
        '{8'h22, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 1'b0}, // R9 inverted
        '{8'h01, 1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 1'b0}, // R3 drive
        '{8'h03, 1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0}, // R3 drive inv
        '{8'h81, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0}, // R4 pull low
        '{8'h81, 1'b1, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0}, // R4 release
        '{8'h08, 1'b0, 3'b001, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 1'b0}, // R6 alt out
        '{8'h0A, 1'b0, 3'b001, 1'b1, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R6 pol ignored
        '{8'h88, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0}, // R6 od low
        '{8'h89, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0}, // R6 od release
        '{8'h10, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0}, // R7 code 10
        '{8'h12, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0}, // R7 honours pol
        '{8'h11, 1'b1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0}, // R7 dir ignored
        '{8'h1A, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b011, 1'b0}, // R7 code 11
        '{8'h19, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0}, // R8 high
        '{8'h3A, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b011, 1'b1}  // R9 alt
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d);
        cfg_mode  = 1'b1;
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_mode = 1'b1;
        #0.1;
        check("R1", "reset word", cfg_rdata, 8'h00);
        check("R1", "reset oe", {7'b0, pad_oe}, 8'h00);
        check("R8", "reset alt_rcv", {5'b0, alt_rcv}, 8'h07);
        check("R9", "reset irq", {7'b0, irq}, 8'h00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            write_cfg(VECS[i].cfg);
            gpio_wdata = VECS[i].wd;
            alt_drv    = VECS[i].ad;
            pad_in     = VECS[i].pin;
            repeat (3) @(negedge clk);
            check("R1", $sformatf("v%0d word", i), cfg_rdata, VECS[i].cfg & 8'hBB);
            check("R3/R4/R6/R7", $sformatf("v%0d pad_oe", i), {7'b0, pad_oe}, {7'b0, VECS[i].oe});
            check("R3/R4/R6", $sformatf("v%0d pad_out", i), {7'b0, pad_out}, {7'b0, VECS[i].out});
            check("R5", $sformatf("v%0d gpio_rdata", i), {7'b0, gpio_rdata}, {7'b0, VECS[i].rd});
            check("R7/R8", $sformatf("v%0d alt_rcv", i), {5'b0, alt_rcv}, {5'b0, VECS[i].ar});
            check("R9", $sformatf("v%0d irq", i), {7'b0, irq}, {7'b0, VECS[i].irq});
        end

        // R2 reserved bits read zero
        write_cfg(8'hFF);
        @(negedge clk);
        check("R2", "reserved bits", cfg_rdata, 8'hBB);

        // R2 write outside configuration mode has no effect
        write_cfg(8'h00);
        gpio_wdata = 1'b0;
        cfg_mode   = 1'b0;
        #0.1;
        check("R1", "blank outside mode", cfg_rdata, 8'h00);
        cfg_wr    = 1'b1;
        cfg_wdata = 8'h01;
        @(negedge clk);
        cfg_wr    = 1'b0;
        @(negedge clk);
        check("R2", "locked pad_oe", {7'b0, pad_oe}, 8'h00);
        cfg_mode = 1'b1;
        #0.1;
        check("R2", "locked word", cfg_rdata, 8'h00);

        // R5 two-edge synchronizer latency
        pad_in = 1'b0;
        repeat (3) @(negedge clk);
        pad_in = 1'b1;
        @(negedge clk);
        check("R5", "after one edge", {7'b0, gpio_rdata}, 8'h00);
        @(negedge clk);
        check("R5", "after two edges", {7'b0, gpio_rdata}, 8'h01);

        finish_run();
    end

endmodule